// File: doc/BRIEF.md
# Serial Control Register Port

This block takes control settings from a three-wire serial port: a data line, a shift clock and a latch-enable line. Bits are shifted into a 12-bit word. When latch enable rises, the first bit of that word chooses where the other 11 bits go. They go either to an 11-bit attenuation register or to a small mode register that holds the deemphasis controls. All three serial lines and the mode-select strap are asynchronous to the block clock, so the block synchronizes them before using them.

When the mode-select strap is low, the serial port is idle. In that state the deemphasis controls come straight from three strap pins, and the attenuation output reads unity gain. The registers keep their contents and appear again at the outputs when the strap returns high.

Top module: `serial_ctrl_port`

## Requirements
- R1: After reset the attenuation register holds 11'h7FF, and the mode register is cleared: deemphasis off, rate code 2'b00.
- R2: With serEnable high, serData is sampled on each rising serClk edge and shifted in first-bit-first. A rising latchEn edge acts on the 12 bits held at that moment.
- R3: If the first of the 12 bits is 0, the other 11 bits are loaded into the attenuation register as an unsigned value, most significant bit first. The mode register is left unchanged.
- R4: If the first bit is 1, the word goes to the mode register and the attenuation register is left unchanged.
- R5: If more than 12 bits are shifted before latchEn rises, only the last 12 are used.
- R6: Rising serClk edges that arrive while latchEn is high do not change the shifted word.
- R7: Mode word decode, counting the last bit shifted as bit 0: bit 0 sets deemOn, and bits 2:1 set deemRate (bit 2 is shifted before bit 1). Code 00 means 44.1 kHz, 01 means 48 kHz and 10 means 32 kHz. The unused code 11 is output as 00.
- R8: With serEnable low, deemOn follows pinDeemOn and deemRate follows pinRate, using the R7 encoding with 11 output as 00. attenCode reads 11'h7FF.
- R9: With serEnable low, serial traffic leaves both registers unchanged. Their old values appear again once serEnable returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| serEnable | input | 1 | Mode-select strap: high selects serial control, low selects the strap pins |
| serData | input | 1 | Serial data line |
| serClk | input | 1 | Serial shift clock |
| latchEn | input | 1 | Latch enable; its rising edge commits the word |
| pinDeemOn | input | 1 | Strap for deemphasis enable |
| pinRate | input | 2 | Strap for deemphasis rate code |
| attenCode | output | 11 | Attenuation code, where 7FF is unity gain |
| deemOn | output | 1 | Deemphasis enable |
| deemRate | output | 2 | Deemphasis rate code |

## Verification
Each serial line passes through two synchronizer stages and then an edge-detect register. A register update therefore shows at the outputs after the third clock edge that follows a latchEn rise, and the serEnable mux switches after the second edge. The driver holds every serial level for at least three clocks and finishes each latch pulse before it pushes an expected item. Each item is due two cycles later. The monitor samples on the falling clock edge, and the next stimulus is at least four cycles away, so every comparison falls inside a window where the outputs are settled.

// File: rtl/scp_pkg.sv
package scp_pkg;
  typedef struct packed {
    logic shift;
    logic latch;
  } scpStrobe_t;

  localparam logic [1:0] RATE_44K1 = 2'b00;
  localparam logic [1:0] RATE_48K  = 2'b01;
  localparam logic [1:0] RATE_32K  = 2'b10;

  localparam int DEEM_ON_BIT = 0;
  localparam int RATE_LSB    = 1;
  localparam int MODE_W      = 3;
endpackage

// File: rtl/scp_ctrl.sv
module scp_ctrl
  import scp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       serEnable,
  input  logic       serData,
  input  logic       serClk,
  input  logic       latchEn,
  output scpStrobe_t stb,
  output logic       serEnSync,
  output logic       dataSync
);
  localparam int NUM_LINES = 4;
  localparam int IDX_DATA  = 0;
  localparam int IDX_CLK   = 1;
  localparam int IDX_LATCH = 2;
  localparam int IDX_EN    = 3;

  logic [NUM_LINES-1:0] rawLines;
  logic [NUM_LINES-1:0] syncLines;
  logic prevClk, prevLatch;
  logic clkRise, latchRise;

  assign rawLines = {serEnable, latchEn, serClk, serData};

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_sync
    logic [SYNC_STAGES-1:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) q <= '0;
      else       q <= {q[SYNC_STAGES-2:0], rawLines[i]};
    end
    assign syncLines[i] = q[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevClk   <= 1'b0;
      prevLatch <= 1'b0;
    end else begin
      prevClk   <= syncLines[IDX_CLK];
      prevLatch <= syncLines[IDX_LATCH];
    end
  end

  assign clkRise   = syncLines[IDX_CLK] & ~prevClk;
  assign latchRise = syncLines[IDX_LATCH] & ~prevLatch;
  assign serEnSync = syncLines[IDX_EN];
  assign dataSync  = syncLines[IDX_DATA];

  always_comb begin
    stb.shift = serEnSync & clkRise & ~syncLines[IDX_LATCH];
    stb.latch = serEnSync & latchRise;
  end
endmodule

// File: rtl/scp_dp.sv
module scp_dp
  import scp_pkg::*;
#(
  parameter int ATT_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  scpStrobe_t        stb,
  input  logic              serEn,
  input  logic              dataIn,
  input  logic              pinDeemOn,
  input  logic [1:0]        pinRate,
  output logic [ATT_W-1:0]  attenCode,
  output logic              deemOn,
  output logic [1:0]        deemRate,
  output logic [ATT_W:0]    wordReg,
  output logic [ATT_W-1:0]  attReg,
  output logic [MODE_W-1:0] modeReg
);
  localparam int WORD_W = ATT_W + 1;

  function automatic logic [1:0] fixRate(input logic [1:0] code);
    return (code == 2'b11) ? RATE_44K1 : code;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wordReg <= '0;
    else if (stb.shift) wordReg <= {wordReg[WORD_W-2:0], dataIn};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      attReg  <= '1;
      modeReg <= '0;
    end else if (stb.latch) begin
      if (wordReg[WORD_W-1]) modeReg <= wordReg[MODE_W-1:0];
      else                   attReg  <= wordReg[ATT_W-1:0];
    end
  end

  always_comb begin
    if (serEn) begin
      attenCode = attReg;
      deemOn    = modeReg[DEEM_ON_BIT];
      deemRate  = fixRate(modeReg[RATE_LSB+1:RATE_LSB]);
    end else begin
      attenCode = '1;
      deemOn    = pinDeemOn;
      deemRate  = fixRate(pinRate);
    end
  end
endmodule

// File: rtl/serial_ctrl_port.sv
module serial_ctrl_port
  import scp_pkg::*;
#(
  parameter int ATT_W       = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             serEnable,
  input  logic             serData,
  input  logic             serClk,
  input  logic             latchEn,
  input  logic             pinDeemOn,
  input  logic [1:0]       pinRate,
  output logic [ATT_W-1:0] attenCode,
  output logic             deemOn,
  output logic [1:0]       deemRate
);
  scpStrobe_t        stb;
  logic              serEnSync;
  logic              dataSync;
  logic [ATT_W:0]    wordReg;
  logic [ATT_W-1:0]  attReg;
  logic [MODE_W-1:0] modeReg;

  scp_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .serEnable(serEnable), .serData(serData),
    .serClk(serClk), .latchEn(latchEn), .stb(stb),
    .serEnSync(serEnSync), .dataSync(dataSync)
  );

  scp_dp #(.ATT_W(ATT_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .serEn(serEnSync), .dataIn(dataSync),
    .pinDeemOn(pinDeemOn), .pinRate(pinRate), .attenCode(attenCode),
    .deemOn(deemOn), .deemRate(deemRate), .wordReg(wordReg),
    .attReg(attReg), .modeReg(modeReg)
  );
endmodule

// File: rtl/scp_checker.sv
module scp_checker
  import scp_pkg::*;
#(
  parameter int ATT_W = 11
) (
  input logic              clk,
  input logic              rstN,
  input logic              serEnable,
  input scpStrobe_t        stb,
  input logic [ATT_W:0]    wordReg,
  input logic [ATT_W-1:0]  attReg,
  input logic [MODE_W-1:0] modeReg,
  input logic [ATT_W-1:0]  attenCode
);
  localparam int WORD_W = ATT_W + 1;

  a_r2_word_shifts: assert property (@(posedge clk) disable iff (!rstN)
    stb.shift |=> wordReg[WORD_W-1:1] == $past(wordReg[WORD_W-2:0]));

  a_r6_word_holds: assert property (@(posedge clk) disable iff (!rstN)
    !stb.shift |=> $stable(wordReg));

  a_r3_att_load: assert property (@(posedge clk) disable iff (!rstN)
    (stb.latch && !wordReg[WORD_W-1]) |=> attReg == $past(wordReg[ATT_W-1:0]));

  a_r3_mode_kept: assert property (@(posedge clk) disable iff (!rstN)
    (stb.latch && !wordReg[WORD_W-1]) |=> $stable(modeReg));

  a_r4_mode_load: assert property (@(posedge clk) disable iff (!rstN)
    (stb.latch && wordReg[WORD_W-1]) |=> modeReg == $past(wordReg[MODE_W-1:0]));

  a_r4_att_kept: assert property (@(posedge clk) disable iff (!rstN)
    (stb.latch && wordReg[WORD_W-1]) |=> $stable(attReg));

  a_r9_regs_hold: assert property (@(posedge clk) disable iff (!rstN)
    !stb.latch |=> ($stable(attReg) && $stable(modeReg)));

  a_r8_pin_unity: assert property (@(posedge clk) disable iff (!rstN)
    (!serEnable && !$past(serEnable) && !$past(serEnable, 2) && !$past(serEnable, 3))
      |-> attenCode == '1);
endmodule

bind serial_ctrl_port scp_checker #(.ATT_W(ATT_W)) u_chk (
  .clk(clk), .rstN(rstN), .serEnable(serEnable), .stb(stb),
  .wordReg(wordReg), .attReg(attReg), .modeReg(modeReg), .attenCode(attenCode)
);

// File: tb/serial_ctrl_port_bench.sv
module serial_ctrl_port_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serEnable = 1'b1, serData = 1'b0, serClk = 1'b0, latchEn = 1'b0;
  logic pinDeemOn = 1'b0;
  logic [1:0] pinRate = 2'b00;
  logic [10:0] attenCode;
  logic deemOn;
  logic [1:0] deemRate;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  typedef struct {
    logic [10:0] att;
    logic        on;
    logic [1:0]  rate;
    int          due;
    string       req;
  } item_t;
  item_t q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  serial_ctrl_port u_serial_ctrl_port (
    .clk(clk), .rstN(rstN), .serEnable(serEnable), .serData(serData),
    .serClk(serClk), .latchEn(latchEn), .pinDeemOn(pinDeemOn), .pinRate(pinRate),
    .attenCode(attenCode), .deemOn(deemOn), .deemRate(deemRate)
  );

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic shiftBit(logic b);
    serData = b; tick(3);
    serClk = 1'b1; tick(3);
    serClk = 1'b0; tick(1);
  endtask

  task automatic sendBits(logic [14:0] bits, int n);
    for (int i = n - 1; i >= 0; i--) shiftBit(bits[i]);
  endtask

  task automatic pulseLatch();
    latchEn = 1'b1; tick(4);
    latchEn = 1'b0; tick(3);
  endtask

  task automatic expectOut(logic [10:0] a, logic o, logic [1:0] r, string req);
    item_t it;
    it.att = a; it.on = o; it.rate = r; it.due = cyc + 2; it.req = req;
    q.push_back(it);
    tick(6);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      while (q.size() > 0 && q[0].due <= cyc) begin
        item_t it;
        it = q.pop_front();
        total++;
        if (attenCode !== it.att || deemOn !== it.on || deemRate !== it.rate) begin
          bad++;
          $display("FAIL %s: actual att=%h on=%b rate=%b expected att=%h on=%b rate=%b",
                   it.req, attenCode, deemOn, deemRate, it.att, it.on, it.rate);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : driver
    tick(4);
    rstN = 1'b1;
    tick(4);
    expectOut(11'h7FF, 1'b0, 2'b00, "R1 reset");
    // R2 R3: attenuation word, leading 0
    sendBits(15'h02AA, 12); pulseLatch();
    expectOut(11'h2AA, 1'b0, 2'b00, "R3 att load");
    // R4 R7: mode word, on=1 rate=48k
    sendBits(15'h0803, 12); pulseLatch();
    expectOut(11'h2AA, 1'b1, 2'b01, "R4 mode load att kept");
    // R5: three extra leading ones, then att 000
    sendBits({3'b111, 12'h000}, 15); pulseLatch();
    expectOut(11'h000, 1'b1, 2'b01, "R5 last 12 bits");
    sendBits(15'h0804, 12); pulseLatch();
    expectOut(11'h000, 1'b0, 2'b10, "R7 rate 32k");
    sendBits(15'h0807, 12); pulseLatch();
    expectOut(11'h000, 1'b1, 2'b00, "R7 code 11 as 00");
    sendBits(15'h07FE, 12); pulseLatch();
    expectOut(11'h7FE, 1'b1, 2'b00, "R2 att 7FE");
    sendBits(15'h0001, 12); pulseLatch();
    expectOut(11'h001, 1'b1, 2'b00, "R3 att 001");
    // R6: shifts while latch high are ignored; a second latch reuses the word
    sendBits(15'h0155, 12);
    latchEn = 1'b1; tick(4);
    for (int k = 0; k < 4; k++) shiftBit(1'b1);
    latchEn = 1'b0; tick(3);
    expectOut(11'h155, 1'b1, 2'b00, "R6 first latch");
    pulseLatch();
    expectOut(11'h155, 1'b1, 2'b00, "R6 shifts ignored");
    // R8: pin mode
    pinDeemOn = 1'b1; pinRate = 2'b10;
    serEnable = 1'b0; tick(4);
    expectOut(11'h7FF, 1'b1, 2'b10, "R8 pin mode");
    pinRate = 2'b11; pinDeemOn = 1'b0; tick(1);
    expectOut(11'h7FF, 1'b0, 2'b00, "R8 pin code 11");
    // R9: serial traffic ignored in pin mode
    sendBits(15'h0123, 12); pulseLatch();
    sendBits(15'h0802, 12); pulseLatch();
    expectOut(11'h7FF, 1'b0, 2'b00, "R9 pin mode outputs");
    serEnable = 1'b1; tick(4);
    expectOut(11'h155, 1'b1, 2'b00, "R9 registers kept");
    tick(10);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule